// File: doc/BRIEF.md
# Power Gating Control Sequencer

This block runs the shutdown and wake-up sequence for a parameterised number of switchable power domains. Each domain has its own request pair and its own four control strobes: a state-save pulse for retention flops, an isolation enable for the clamp cells, a power switch enable, and a state-restore pulse. A shutdown request makes the domain pulse save, then raise isolation, then drop power. A wake-up request makes it raise power, then drop isolation, then pulse restore.

Every width and gap in those sequences comes from a shared set of configuration inputs, counted in clock cycles. A configured value of zero acts as one, except for the idle delay, where zero means no delay. Each domain reports a busy level and a one-cycle done pulse. Requests that arrive in the wrong state, during a sequence, or too soon after the previous sequence are dropped and latch a per-domain error flag.

Top module: `pwr_gate_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, every domain has power enable high, isolation low, save low, restore low, and busy, done and error low.
- R2: With a shutdown request accepted at clock edge E, save rises at E. It issues P pulses, where P is the configured pulse count. Each pulse is high for W_s cycles, and consecutive pulses are separated by W_s low cycles. Isolation rises G_si cycles after the last save falls. Power enable falls G_ip cycles after isolation rises. A zero value in any of these fields behaves as one.
- R3: With a wake-up request accepted at edge A, power enable rises at max(Poff + D, A + 1), where Poff is the power-off edge and D is the minimum off time. Isolation falls at max(Pon + G_oi, Iso + W_i), where Iso is the edge at which isolation rose and W_i is the minimum isolation width. Restore rises G_ir cycles after isolation falls. It issues P pulses, each W_r cycles high with W_r low cycles between them.
- R4: Within one domain, at most one of save, isolation, power enable and restore changes value on any clock edge.
- R5: Busy rises at the edge that accepts a request. It falls at the edge of the final strobe change: the power-off edge for shutdown, the last restore fall for wake-up. Done is high for exactly the one cycle that begins at that edge.
- R6: After a sequence completes at edge F, a request is accepted no earlier than edge F + I + 1, where I is the idle delay. An earlier request leaves all outputs unchanged and sets the error flag.
- R7: A wake-up request to a powered domain, a shutdown request to an unpowered domain, or both requests in the same cycle are ignored and set the domain's error flag. The flag stays set until reset.
- R8: Each domain sequences independently; activity in one domain leaves the outputs of every other domain unchanged.
- R9: After reset the four control strobes of every domain are never X or Z.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_off | input | NUM_DOM | Per-domain shutdown request, sampled each edge |
| req_on | input | NUM_DOM | Per-domain wake-up request, sampled each edge |
| cfg_save_w | input | CW | Save pulse width W_s |
| cfg_save_iso_gap | input | CW | Last save fall to isolation rise G_si |
| cfg_iso_off_gap | input | CW | Isolation rise to power-off G_ip |
| cfg_off_min | input | CW | Minimum power-off time D |
| cfg_on_iso_gap | input | CW | Power-on to isolation release G_oi |
| cfg_iso_min | input | CW | Minimum total isolation width W_i |
| cfg_rel_rst_gap | input | CW | Isolation release to first restore G_ir |
| cfg_rst_w | input | CW | Restore pulse width W_r |
| cfg_idle | input | CW | Minimum idle cycles between sequences I |
| cfg_pulses | input | PW | Save/restore pulses per sequence P |
| pg_save | output | NUM_DOM | Retention save strobe |
| pg_iso | output | NUM_DOM | Isolation enable |
| pg_pwr_en | output | NUM_DOM | Power switch enable, high means powered |
| pg_restore | output | NUM_DOM | Retention restore strobe |
| busy | output | NUM_DOM | Sequence in progress |
| done | output | NUM_DOM | One-cycle completion pulse |
| err | output | NUM_DOM | Sticky rejected-request flag |

## Verification
Two timing functions can fall in the same cycle in several places, and each is judged against a max() in the bench.

- **Power-on time.** It is set both by the wake request (A + 1) and by the minimum off time (Poff + D). The sweep sets both bounds equal in one configuration, and lets each dominate in the others.
- **Isolation release.** It is likewise bounded by the power-on gap and by the total isolation width. Configurations with a long minimum width and configurations with a short one decide which bound wins.
- **Idle window.** A request is placed one cycle before the idle window ends, then exactly at its end. The first must be rejected and the second accepted.

Each window is compared cycle by cycle against the waveform the bench derives from the formulas.

// File: rtl/pwr_gate_pkg.sv
package pwr_gate_pkg;

    // Sequencer phases; one strobe changes on each phase exit
    typedef enum logic [3:0] {
        PH_ON_IDLE,
        PH_SAVE_HI,
        PH_SAVE_LO,
        PH_SAVE_GAP,
        PH_ISO_GAP,
        PH_OFF_IDLE,
        PH_OFF_HOLD,
        PH_ON_GAP,
        PH_REL_GAP,
        PH_RST_HI,
        PH_RST_LO
    } pg_phase_e;

endpackage

// File: rtl/pwr_gate_cfg_clamp.sv
module pwr_gate_cfg_clamp #(
    parameter int CW = 4,
    parameter int PW = 2
) (
    input  logic [CW-1:0] raw_save_w,
    input  logic [CW-1:0] raw_save_iso_gap,
    input  logic [CW-1:0] raw_iso_off_gap,
    input  logic [CW-1:0] raw_off_min,
    input  logic [CW-1:0] raw_on_iso_gap,
    input  logic [CW-1:0] raw_iso_min,
    input  logic [CW-1:0] raw_rel_rst_gap,
    input  logic [CW-1:0] raw_rst_w,
    input  logic [PW-1:0] raw_pulses,
    output logic [CW-1:0] c_save_w,
    output logic [CW-1:0] c_save_iso_gap,
    output logic [CW-1:0] c_iso_off_gap,
    output logic [CW-1:0] c_off_min,
    output logic [CW-1:0] c_on_iso_gap,
    output logic [CW-1:0] c_iso_min,
    output logic [CW-1:0] c_rel_rst_gap,
    output logic [CW-1:0] c_rst_w,
    output logic [PW-1:0] c_pulses
);

    localparam int NFIELD = 8;

    logic [CW-1:0] raw_arr [NFIELD];
    logic [CW-1:0] cl_arr  [NFIELD];

    assign raw_arr[0] = raw_save_w;
    assign raw_arr[1] = raw_save_iso_gap;
    assign raw_arr[2] = raw_iso_off_gap;
    assign raw_arr[3] = raw_off_min;
    assign raw_arr[4] = raw_on_iso_gap;
    assign raw_arr[5] = raw_iso_min;
    assign raw_arr[6] = raw_rel_rst_gap;
    assign raw_arr[7] = raw_rst_w;

    // A zero width or gap would make two strobes move together; force one
    for (genvar f = 0; f < NFIELD; f++) begin : g_clamp
        assign cl_arr[f] = (raw_arr[f] == '0) ? CW'(1) : raw_arr[f];
    end

    assign c_save_w       = cl_arr[0];
    assign c_save_iso_gap = cl_arr[1];
    assign c_iso_off_gap  = cl_arr[2];
    assign c_off_min      = cl_arr[3];
    assign c_on_iso_gap   = cl_arr[4];
    assign c_iso_min      = cl_arr[5];
    assign c_rel_rst_gap  = cl_arr[6];
    assign c_rst_w        = cl_arr[7];
    assign c_pulses       = (raw_pulses == '0) ? PW'(1) : raw_pulses;

endmodule

// File: rtl/pwr_gate_dom.sv
module pwr_gate_dom
    import pwr_gate_pkg::*;
#(
    parameter int CW = 4,
    parameter int PW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_off,
    input  logic          req_on,
    input  logic [CW-1:0] save_w,
    input  logic [CW-1:0] save_iso_gap,
    input  logic [CW-1:0] iso_off_gap,
    input  logic [CW-1:0] off_min,
    input  logic [CW-1:0] on_iso_gap,
    input  logic [CW-1:0] iso_min,
    input  logic [CW-1:0] rel_rst_gap,
    input  logic [CW-1:0] rst_w,
    input  logic [CW-1:0] idle_gap,
    input  logic [PW-1:0] pulses,
    output logic          save_o,
    output logic          iso_o,
    output logic          pwr_o,
    output logic          rst_o,
    output logic          busy_o,
    output logic          done_o,
    output logic          err_o
);

    typedef struct packed {
        pg_phase_e     ph;
        logic [CW-1:0] cnt;
        logic [CW-1:0] iso_cnt;
        logic [PW-1:0] pls;
        logic          save;
        logic          iso;
        logic          pwr;
        logic          rst;
        logic          busy;
        logic          done;
        logic          err;
    } dom_t;

    dom_t st_d, st_q;

    logic take_off, take_on, idle_ok, any_req;

    function automatic logic hit(input logic [CW-1:0] c, input logic [CW-1:0] w);
        return ((CW+1)'(c) + (CW+1)'(1)) >= (CW+1)'(w);
    endfunction

    function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] c);
        return (c == {CW{1'b1}}) ? c : c + CW'(1);
    endfunction

    always_comb begin
        idle_ok  = (st_q.cnt >= idle_gap);
        any_req  = req_off | req_on;
        take_off = req_off & ~req_on & (st_q.ph == PH_ON_IDLE)  & idle_ok;
        take_on  = req_on  & ~req_off & (st_q.ph == PH_OFF_IDLE) & idle_ok;

        st_d         = st_q;
        st_d.done    = 1'b0;
        st_d.cnt     = sat_inc(st_q.cnt);
        st_d.iso_cnt = st_q.iso ? sat_inc(st_q.iso_cnt) : st_q.iso_cnt;
        if (any_req && !take_off && !take_on) begin
            st_d.err = 1'b1;
        end

        unique case (st_q.ph)
            PH_ON_IDLE: begin
                if (take_off) begin
                    st_d.ph   = PH_SAVE_HI;
                    st_d.save = 1'b1;
                    st_d.busy = 1'b1;
                    st_d.cnt  = '0;
                    st_d.pls  = PW'(1);
                end
            end
            PH_SAVE_HI: begin
                if (hit(st_q.cnt, save_w)) begin
                    st_d.save = 1'b0;
                    st_d.cnt  = '0;
                    st_d.ph   = (st_q.pls >= pulses) ? PH_SAVE_GAP : PH_SAVE_LO;
                end
            end
            PH_SAVE_LO: begin
                if (hit(st_q.cnt, save_w)) begin
                    st_d.save = 1'b1;
                    st_d.cnt  = '0;
                    st_d.pls  = st_q.pls + PW'(1);
                    st_d.ph   = PH_SAVE_HI;
                end
            end
            PH_SAVE_GAP: begin
                if (hit(st_q.cnt, save_iso_gap)) begin
                    st_d.iso     = 1'b1;
                    st_d.iso_cnt = '0;
                    st_d.cnt     = '0;
                    st_d.ph      = PH_ISO_GAP;
                end
            end
            PH_ISO_GAP: begin
                if (hit(st_q.cnt, iso_off_gap)) begin
                    st_d.pwr  = 1'b0;
                    st_d.busy = 1'b0;
                    st_d.done = 1'b1;
                    st_d.cnt  = '0;
                    st_d.ph   = PH_OFF_IDLE;
                end
            end
            PH_OFF_IDLE: begin
                if (take_on) begin
                    st_d.ph   = PH_OFF_HOLD;
                    st_d.busy = 1'b1;
                end
            end
            PH_OFF_HOLD: begin
                // cnt keeps running from the power-off edge
                if (hit(st_q.cnt, off_min)) begin
                    st_d.pwr = 1'b1;
                    st_d.cnt = '0;
                    st_d.ph  = PH_ON_GAP;
                end
            end
            PH_ON_GAP: begin
                if (hit(st_q.cnt, on_iso_gap) && hit(st_q.iso_cnt, iso_min)) begin
                    st_d.iso = 1'b0;
                    st_d.cnt = '0;
                    st_d.ph  = PH_REL_GAP;
                end
            end
            PH_REL_GAP: begin
                if (hit(st_q.cnt, rel_rst_gap)) begin
                    st_d.rst = 1'b1;
                    st_d.cnt = '0;
                    st_d.pls = PW'(1);
                    st_d.ph  = PH_RST_HI;
                end
            end
            PH_RST_HI: begin
                if (hit(st_q.cnt, rst_w)) begin
                    st_d.rst = 1'b0;
                    st_d.cnt = '0;
                    if (st_q.pls >= pulses) begin
                        st_d.busy = 1'b0;
                        st_d.done = 1'b1;
                        st_d.ph   = PH_ON_IDLE;
                    end else begin
                        st_d.ph = PH_RST_LO;
                    end
                end
            end
            PH_RST_LO: begin
                if (hit(st_q.cnt, rst_w)) begin
                    st_d.rst = 1'b1;
                    st_d.cnt = '0;
                    st_d.pls = st_q.pls + PW'(1);
                    st_d.ph  = PH_RST_HI;
                end
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph      <= PH_ON_IDLE;
            st_q.cnt     <= '1;
            st_q.iso_cnt <= '0;
            st_q.pls     <= '0;
            st_q.save    <= 1'b0;
            st_q.iso     <= 1'b0;
            st_q.pwr     <= 1'b1;
            st_q.rst     <= 1'b0;
            st_q.busy    <= 1'b0;
            st_q.done    <= 1'b0;
            st_q.err     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign save_o = st_q.save;
    assign iso_o  = st_q.iso;
    assign pwr_o  = st_q.pwr;
    assign rst_o  = st_q.rst;
    assign busy_o = st_q.busy;
    assign done_o = st_q.done;
    assign err_o  = st_q.err;

    logic [3:0] strb;
    assign strb = {save_o, iso_o, pwr_o, rst_o};

    // R4
    one_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(strb ^ $past(strb)) <= 1);
    // R9
    strobe_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(strb));
    // R2
    off_under_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_o) |-> (iso_o && !save_o && !rst_o));
    // R2
    save_while_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(save_o) |-> (pwr_o && !iso_o && !rst_o));
    // R3
    release_when_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(iso_o) |-> pwr_o);
    // R3
    restore_when_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_o) |-> (pwr_o && !iso_o && !save_o));
    // R5
    busy_end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);
    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

endmodule

// File: rtl/pwr_gate_seq.sv
module pwr_gate_seq #(
    parameter int NUM_DOM = 2,
    parameter int CW      = 4,
    parameter int PW      = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_DOM-1:0] req_off,
    input  logic [NUM_DOM-1:0] req_on,
    input  logic [CW-1:0]      cfg_save_w,
    input  logic [CW-1:0]      cfg_save_iso_gap,
    input  logic [CW-1:0]      cfg_iso_off_gap,
    input  logic [CW-1:0]      cfg_off_min,
    input  logic [CW-1:0]      cfg_on_iso_gap,
    input  logic [CW-1:0]      cfg_iso_min,
    input  logic [CW-1:0]      cfg_rel_rst_gap,
    input  logic [CW-1:0]      cfg_rst_w,
    input  logic [CW-1:0]      cfg_idle,
    input  logic [PW-1:0]      cfg_pulses,
    output logic [NUM_DOM-1:0] pg_save,
    output logic [NUM_DOM-1:0] pg_iso,
    output logic [NUM_DOM-1:0] pg_pwr_en,
    output logic [NUM_DOM-1:0] pg_restore,
    output logic [NUM_DOM-1:0] busy,
    output logic [NUM_DOM-1:0] done,
    output logic [NUM_DOM-1:0] err
);

    logic [CW-1:0] k_save_w, k_save_iso_gap, k_iso_off_gap, k_off_min;
    logic [CW-1:0] k_on_iso_gap, k_iso_min, k_rel_rst_gap, k_rst_w;
    logic [PW-1:0] k_pulses;

    pwr_gate_cfg_clamp #(.CW(CW), .PW(PW)) u_clamp (
        .raw_save_w       (cfg_save_w),
        .raw_save_iso_gap (cfg_save_iso_gap),
        .raw_iso_off_gap  (cfg_iso_off_gap),
        .raw_off_min      (cfg_off_min),
        .raw_on_iso_gap   (cfg_on_iso_gap),
        .raw_iso_min      (cfg_iso_min),
        .raw_rel_rst_gap  (cfg_rel_rst_gap),
        .raw_rst_w        (cfg_rst_w),
        .raw_pulses       (cfg_pulses),
        .c_save_w         (k_save_w),
        .c_save_iso_gap   (k_save_iso_gap),
        .c_iso_off_gap    (k_iso_off_gap),
        .c_off_min        (k_off_min),
        .c_on_iso_gap     (k_on_iso_gap),
        .c_iso_min        (k_iso_min),
        .c_rel_rst_gap    (k_rel_rst_gap),
        .c_rst_w          (k_rst_w),
        .c_pulses         (k_pulses)
    );

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        pwr_gate_dom #(.CW(CW), .PW(PW)) u_dom (
            .clk          (clk),
            .rst_n        (rst_n),
            .req_off      (req_off[d]),
            .req_on       (req_on[d]),
            .save_w       (k_save_w),
            .save_iso_gap (k_save_iso_gap),
            .iso_off_gap  (k_iso_off_gap),
            .off_min      (k_off_min),
            .on_iso_gap   (k_on_iso_gap),
            .iso_min      (k_iso_min),
            .rel_rst_gap  (k_rel_rst_gap),
            .rst_w        (k_rst_w),
            .idle_gap     (cfg_idle),
            .pulses       (k_pulses),
            .save_o       (pg_save[d]),
            .iso_o        (pg_iso[d]),
            .pwr_o        (pg_pwr_en[d]),
            .rst_o        (pg_restore[d]),
            .busy_o       (busy[d]),
            .done_o       (done[d]),
            .err_o        (err[d])
        );
    end

endmodule

// File: tb/sim_pwr_gate_seq.sv
module sim_pwr_gate_seq;
    localparam int ND = 2;
    localparam int CW = 4;
    localparam int PW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [ND-1:0] req_off = '0, req_on = '0;
    logic [CW-1:0] c_sw = 1, c_g1 = 1, c_g2 = 1, c_dm = 1, c_g3 = 1, c_iw = 1, c_g4 = 1, c_rw = 1, c_idl = 0;
    logic [PW-1:0] c_np = 1;
    logic [ND-1:0] o_save, o_iso, o_pwr, o_rst, o_busy, o_done, o_err;

    pwr_gate_seq #(.NUM_DOM(ND), .CW(CW), .PW(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_off(req_off), .req_on(req_on),
        .cfg_save_w(c_sw), .cfg_save_iso_gap(c_g1), .cfg_iso_off_gap(c_g2),
        .cfg_off_min(c_dm), .cfg_on_iso_gap(c_g3), .cfg_iso_min(c_iw),
        .cfg_rel_rst_gap(c_g4), .cfg_rst_w(c_rw), .cfg_idle(c_idl), .cfg_pulses(c_np),
        .pg_save(o_save), .pg_iso(o_iso), .pg_pwr_en(o_pwr), .pg_restore(o_rst),
        .busy(o_busy), .done(o_done), .err(o_err)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int total = 0, bad = 0;
    int last_pf [ND];
    int last_ir [ND];
    int last_dn [ND];

    task automatic check(input bit ok, input string rq, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic int cl(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic bit in_pulse(input int n, input int s, input int w, input int k);
        for (int i = 0; i < k; i++)
            if (n >= s + 2*i*w && n < s + (2*i+1)*w) return 1'b1;
        return 1'b0;
    endfunction

    // {save, iso, pwr, restore, busy, done}
    function automatic logic [5:0] pk(input int d);
        return {o_save[d], o_iso[d], o_pwr[d], o_rst[d], o_busy[d], o_done[d]};
    endfunction

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic run_off(input int d, input int a_min, input string tag);
        int e, pf, ir, np, sw;
        bit b2 = 0, b4 = 0, b5 = 0, b8 = 0, b9 = 0;
        int a2 = 0, x2 = 0, a5 = 0, x5 = 0;
        logic [5:0] prv, cur, oth;
        logic [3:0] xs;
        logic [1:0] xb;
        while (cyc + 1 < a_min) @(negedge clk);
        req_off[d] = 1'b1;
        e = cyc + 1;
        np = cl(int'(c_np)); sw = cl(int'(c_sw));
        ir = e + (2*np - 1)*sw + cl(int'(c_g1));
        pf = ir + cl(int'(c_g2));
        oth = pk(1-d); prv = pk(d);
        for (int n = e; n <= pf + 2; n++) begin
            @(negedge clk);
            req_off[d] = 1'b0;
            cur = pk(d);
            xs = {in_pulse(n, e, sw, np), n >= ir, n < pf, 1'b0};
            xb = {n >= e && n < pf, n == pf};
            if (cur[5:2] !== xs && !b2) begin b2 = 1; a2 = cur[5:2]; x2 = xs; end
            if (cur[1:0] !== xb && !b5) begin b5 = 1; a5 = cur[1:0]; x5 = xb; end
            if ($countones(cur[5:2] ^ prv[5:2]) > 1) b4 = 1;
            if (pk(1-d) !== oth) b8 = 1;
            if ($isunknown(cur)) b9 = 1;
            prv = cur;
        end
        check(!b2, "R2", "shutdown strobes", a2, x2);
        check(!b5, tag, "shutdown busy/done", a5, x5);
        check(!b4, "R4", "single change per edge", int'(b4), 0);
        check(!b8, "R8", "other domain stable", int'(b8), 0);
        check(!b9, "R9", "strobes known", int'(b9), 0);
        last_pf[d] = pf; last_ir[d] = ir; last_dn[d] = pf;
    endtask

    task automatic run_on(input int d, input int extra);
        int a, pon, rel, rs, dn, np, rw;
        bit b3 = 0, b4 = 0, b5 = 0, b8 = 0;
        int a3 = 0, x3 = 0, a5 = 0, x5 = 0;
        logic [5:0] prv, cur, oth;
        logic [3:0] xs;
        logic [1:0] xb;
        while (cyc + 1 < last_pf[d] + int'(c_idl) + 1 + extra) @(negedge clk);
        req_on[d] = 1'b1;
        a = cyc + 1;
        np = cl(int'(c_np)); rw = cl(int'(c_rw));
        pon = mx(last_pf[d] + cl(int'(c_dm)), a + 1);
        rel = mx(pon + cl(int'(c_g3)), last_ir[d] + cl(int'(c_iw)));
        rs  = rel + cl(int'(c_g4));
        dn  = rs + (2*np - 1)*rw;
        oth = pk(1-d); prv = pk(d);
        for (int n = a; n <= dn + 2; n++) begin
            @(negedge clk);
            req_on[d] = 1'b0;
            cur = pk(d);
            xs = {1'b0, n < rel, n >= pon, in_pulse(n, rs, rw, np)};
            xb = {n >= a && n < dn, n == dn};
            if (cur[5:2] !== xs && !b3) begin b3 = 1; a3 = cur[5:2]; x3 = xs; end
            if (cur[1:0] !== xb && !b5) begin b5 = 1; a5 = cur[1:0]; x5 = xb; end
            if ($countones(cur[5:2] ^ prv[5:2]) > 1) b4 = 1;
            if (pk(1-d) !== oth) b8 = 1;
            prv = cur;
        end
        check(!b3, "R3", "wake strobes", a3, x3);
        check(!b5, "R5", "wake busy/done", a5, x5);
        check(!b4, "R4", "single change per edge", int'(b4), 0);
        check(!b8, "R8", "other domain stable", int'(b8), 0);
        last_dn[d] = dn;
    endtask

    initial begin
        @(negedge clk);
        // R1 during reset
        check(pk(0) == 6'b001000 && pk(1) == 6'b001000 && o_err == 0, "R1", "reset state", {pk(0), pk(1)}, 12'h208);
        do_reset();
        check(pk(0) == 6'b001000 && pk(1) == 6'b001000 && o_err == 0, "R1", "after reset", {pk(0), pk(1)}, 12'h208);

        for (int i = 0; i < 12; i++) begin
            c_sw = CW'(1 + i % 3);  c_np = PW'(1 + (i / 3) % 3);
            c_g1 = (i % 2) ? 4'd3 : 4'd0;  c_g2 = CW'(1 + i % 4);
            c_dm = (i < 6) ? 4'd2 : 4'd12; c_g3 = CW'(i % 3);
            c_iw = (i % 2) ? 4'd15 : 4'd0; c_g4 = CW'(i % 5);
            c_rw = (i % 2) ? 4'd3 : 4'd1;  c_idl = CW'(i % 4);
            repeat (20) @(negedge clk);
            run_off(0, 0, "R5");
            run_on(0, i % 3);
        end
        check(o_err == 0, "R7", "no error on legal requests", o_err, 0);

        // R7 wake to powered domain
        req_on[0] = 1'b1; @(negedge clk); req_on[0] = 1'b0;
        check(o_err[0] && pk(0) == 6'b001000, "R7", "wake on powered", {o_err[0], pk(0)}, 7'h48);
        repeat (5) @(negedge clk);
        check(o_err[0] == 1'b1, "R7", "error sticky", o_err[0], 1);
        do_reset();
        check(o_err == 0, "R1", "reset clears error", o_err, 0);

        // idle window and off-to-off
        c_sw = 1; c_np = 1; c_g1 = 1; c_g2 = 1; c_dm = 1; c_g3 = 1; c_iw = 1; c_g4 = 1; c_rw = 1; c_idl = 3;
        run_off(0, 0, "R5");
        while (cyc + 1 < last_pf[0] + 5) @(negedge clk);
        req_off[0] = 1'b1; @(negedge clk); req_off[0] = 1'b0;
        check(o_err[0] && pk(0) == 6'b010000, "R7", "shutdown on unpowered", {o_err[0], pk(0)}, 7'h50);
        do_reset();
        run_off(0, 0, "R5");
        run_on(0, 0);
        // now at negedge with cyc == dn+2: request lands at edge dn+3, one early
        req_off[0] = 1'b1; @(negedge clk); req_off[0] = 1'b0;
        check(o_err[0] && pk(0) == 6'b001000, "R6", "early request ignored", {o_err[0], pk(0)}, 7'h48);
        run_off(0, last_dn[0] + 4, "R6");

        // R7 both requests together on domain 1
        req_off[1] = 1'b1; req_on[1] = 1'b1; @(negedge clk); req_off[1] = 1'b0; req_on[1] = 1'b0;
        @(negedge clk);
        check(o_err[1] && pk(1) == 6'b001000, "R7", "dual request ignored", {o_err[1], pk(1)}, 7'h48);

        // R8 domain 1 sequences while domain 0 stays off
        do_reset();
        c_idl = 0; c_np = 2;
        run_off(0, 0, "R5");
        run_off(1, 0, "R5");
        run_on(1, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        total++; bad++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule